// File: doc/BRIEF.md
# Add/Subtract Flag Generator

This block is the arithmetic half of an integer execute stage. It forms a 32-bit sum or difference from two operands under a 2-bit operation select (plain add, add with carry, plain subtract, subtract with carry). It also produces the four condition flags: negative, zero, carry and overflow. The result is combinational. The flags sit in a small register that is written only when the instruction asks for a flag update.

Carry and overflow do not come from a wide adder's carry-out. Carry comes from an unsigned magnitude comparison between the result and the operands. The carry-in variants add an equality term that breaks ties. Overflow comes from the sign bit of XOR combinations of the result and the operands. Subtraction reports carry as an inverted borrow. A separate load path writes all four flags at once from a packed 4-bit word. That path serves flag restores and compare-style moves.

Top module: `addsub_flags`

## Requirements
- R1: `result` is combinational and depends on `op_sel`. Code 2'b00 gives a+b. Code 2'b01 gives a+b+carry_in. Code 2'b10 gives a-b. Code 2'b11 gives a+~b+carry_in. All results are taken modulo 2^32.
- R2: On a flag update, N becomes result bit 31. Z becomes 1 exactly when all 32 result bits are zero.
- R3: For code 2'b00, C becomes 1 when the unsigned result is below operand a.
- R4: For code 2'b01, C becomes 1 when the unsigned result is below a. It also becomes 1 when the result equals a and carry_in is 1.
- R5: For code 2'b10, C becomes 1 when a is not below b unsigned, so C means no borrow.
- R6: For code 2'b11, C becomes 1 when a is above b unsigned. It also becomes 1 when a equals b and carry_in is 1.
- R7: For the two add codes, V is bit 31 of (result XOR a) AND NOT (a XOR b).
- R8: For the two subtract codes, V is bit 31 of (result XOR a) AND (a XOR b).
- R9: While `flag_load` is high, the next clock edge writes `flag_din` into the flags. Bit 3 goes to N, bit 2 to Z, bit 1 to C and bit 0 to V.
- R10: While `set_flags` and `flag_load` are both low, all four flags keep their values across clock edges, whatever the operands do.
- R11: When `flag_load` and `set_flags` are high together, the packed load wins.
- R12: An active-low reset clears all four flags to 0.
- R13: A flag update driven by `set_flags` takes effect on the clock edge that samples it. The flags then show the values for the operands present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 2 | Operation: 00 add, 01 add with carry, 10 subtract, 11 subtract with carry |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| carry_in | input | 1 | Incoming carry for the carry-in variants |
| set_flags | input | 1 | Write computed flags on the next edge |
| flag_load | input | 1 | Write the packed flag word on the next edge |
| flag_din | input | 4 | Packed flags {N,Z,C,V} |
| result | output | 32 | Arithmetic result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The assertions are checked on every cycle. They compare each stored carry and overflow against an independent 33-bit sum of the previous cycle's operands. They tie N and Z to the previous result, check that the packed load reaches the right flag positions, and check that the flags hold while neither write enable is set. Some behaviour only the bench scenarios can show: the result values themselves, the equality tie-break cases of the carry-in variants at their exact boundaries, the reset value of the flags, and the corner operands 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF. Each of these is compared against a 33-bit reference model.

// File: rtl/afg_pkg.sv
package afg_pkg;
  typedef enum logic [1:0] {
    AFG_ADD = 2'b00,
    AFG_ADC = 2'b01,
    AFG_SUB = 2'b10,
    AFG_SBC = 2'b11
  } afg_op_e;

  // Packed order gives bit3=N, bit2=Z, bit1=C, bit0=V
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } afg_flags_t;
endpackage

// File: rtl/afg_adder.sv
module afg_adder
  import afg_pkg::*;
#(
  parameter int W = 32
) (
  input  afg_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  output logic [W-1:0]   sum
);
  logic [W-1:0] b_eff;
  logic         cy;

  always_comb begin
    unique case (op)
      AFG_ADD: begin b_eff = b;  cy = 1'b0; end
      AFG_ADC: begin b_eff = b;  cy = cin;  end
      AFG_SUB: begin b_eff = ~b; cy = 1'b1; end
      default: begin b_eff = ~b; cy = cin;  end
    endcase
    sum = a + b_eff + W'(cy);
  end
endmodule

// File: rtl/afg_flag_calc.sv
module afg_flag_calc
  import afg_pkg::*;
#(
  parameter int W = 32
) (
  input  afg_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [W-1:0]   res,
  input  logic           cin,
  output afg_flags_t     flags
);
  localparam int MSB = W - 1;

  logic [W-1:0] res_x_a;
  logic [W-1:0] a_x_b;
  logic         is_sub;

  always_comb begin
    is_sub  = (op == AFG_SUB) || (op == AFG_SBC);
    res_x_a = res ^ a;
    a_x_b   = a ^ b;

    flags.n = res[MSB];
    flags.z = (res == '0);

    unique case (op)
      AFG_ADD: flags.c = (res < a);
      AFG_ADC: flags.c = (res < a) || ((res == a) && cin);
      AFG_SUB: flags.c = !(a < b);
      default: flags.c = (a > b) || ((a == b) && cin);
    endcase

    if (is_sub) flags.v = res_x_a[MSB] & a_x_b[MSB];
    else        flags.v = res_x_a[MSB] & ~a_x_b[MSB];
  end
endmodule

// File: rtl/afg_flag_reg.sv
module afg_flag_reg
  import afg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        upd_en,
  input  logic        load_en,
  input  logic [3:0]  load_word,
  input  afg_flags_t  calc,
  output afg_flags_t  q
);
  afg_flags_t d;

  always_comb begin
    d = q;
    if (load_en)     d = afg_flags_t'(load_word);
    else if (upd_en) d = calc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !upd_en && !load_en) |=> $stable(q));

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && load_en) |=> (q.n == $past(load_word[3]) && q.z == $past(load_word[2])
                         && q.c == $past(load_word[1]) && q.v == $past(load_word[0])));
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
  import afg_pkg::*;
#(
  parameter int W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    op_sel,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  input  logic          carry_in,
  input  logic          set_flags,
  input  logic          flag_load,
  input  logic [3:0]    flag_din,
  output logic [W-1:0]  result,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_c,
  output logic          flag_v
);
  afg_op_e    op;
  afg_flags_t calc_flags;
  afg_flags_t cur_flags;

  assign op = afg_op_e'(op_sel);

  afg_adder #(.W(W)) u_adder (
    .op  (op),
    .a   (opnd_a),
    .b   (opnd_b),
    .cin (carry_in),
    .sum (result)
  );

  afg_flag_calc #(.W(W)) u_calc (
    .op    (op),
    .a     (opnd_a),
    .b     (opnd_b),
    .res   (result),
    .cin   (carry_in),
    .flags (calc_flags)
  );

  afg_flag_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (set_flags),
    .load_en   (flag_load),
    .load_word (flag_din),
    .calc      (calc_flags),
    .q         (cur_flags)
  );

  assign flag_n = cur_flags.n;
  assign flag_z = cur_flags.z;
  assign flag_c = cur_flags.c;
  assign flag_v = cur_flags.v;

  // Independent wide-sum model, used only by the assertions below
  logic [W-1:0] chk_b;
  logic [W:0]   chk_wide;
  logic         chk_cy;
  logic         chk_ovf;

  always_comb begin
    chk_b    = op_sel[1] ? ~opnd_b : opnd_b;
    chk_cy   = (op_sel == 2'b00) ? 1'b0 : (op_sel == 2'b10) ? 1'b1 : carry_in;
    chk_wide = {1'b0, opnd_a} + {1'b0, chk_b} + {{W{1'b0}}, chk_cy};
    chk_ovf  = (opnd_a[W-1] == chk_b[W-1]) && (chk_wide[W-1] != opnd_a[W-1]);
  end

  // R3 R4 R5 R6: comparison carry matches the wide-sum carry-out
  p_carry_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && set_flags && !flag_load) |=> (flag_c == $past(chk_wide[W])));

  // R7 R8: sign-bit overflow matches signed overflow of the wide sum
  p_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && set_flags && !flag_load) |=> (flag_v == $past(chk_ovf)));

  p_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && set_flags && !flag_load) |=> (flag_z == ($past(result) == '0)));

  p_neg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && set_flags && !flag_load) |=> (flag_n == $past(result[W-1])));

  p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && set_flags && flag_load) |=> ({flag_n, flag_z, flag_c, flag_v} == $past(flag_din)));
endmodule

// File: tb/addsub_flags_bench.sv
module addsub_flags_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  op_sel;
  logic [31:0] opnd_a, opnd_b;
  logic        carry_in, set_flags, flag_load;
  logic [3:0]  flag_din;
  logic [31:0] result;
  logic        flag_n, flag_z, flag_c, flag_v;

  int n_chk = 0;
  int n_fail = 0;
  logic [3:0] exp_flags;

  always #10 clk = ~clk;

  addsub_flags u_addsub_flags (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .carry_in(carry_in), .set_flags(set_flags), .flag_load(flag_load),
    .flag_din(flag_din), .result(result), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] cur();
    return {flag_n, flag_z, flag_c, flag_v};
  endfunction

  // Apply one operation with a flag update and check result then flags
  task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic ci);
    logic [31:0] bx;
    logic        cy;
    logic [32:0] wide;
    logic [31:0] r;
    string       creq, vreq;
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; carry_in = ci; set_flags = 1'b1; flag_load = 1'b0;
    bx   = op[1] ? ~b : b;
    cy   = (op == 2'b00) ? 1'b0 : (op == 2'b10) ? 1'b1 : ci;
    wide = {1'b0, a} + {1'b0, bx} + {32'd0, cy};
    r    = wide[31:0];
    exp_flags = {r[31], r == 32'd0, wide[32], (a[31] == bx[31]) && (r[31] != a[31])};
    case (op)
      2'b00: creq = "R3"; 2'b01: creq = "R4"; 2'b10: creq = "R5"; default: creq = "R6";
    endcase
    vreq = op[1] ? "R8" : "R7";
    #1 chk("R1 result", result, r);
    @(negedge clk);
    set_flags = 1'b0;
    chk("R2 N", {31'd0, flag_n}, {31'd0, exp_flags[3]});
    chk("R2 Z", {31'd0, flag_z}, {31'd0, exp_flags[2]});
    chk({creq, " C"}, {31'd0, flag_c}, {31'd0, exp_flags[1]});
    chk({vreq, " V"}, {31'd0, flag_v}, {31'd0, exp_flags[0]});
  endtask

  task automatic test_reset();
    chk("R12 reset flags", {28'd0, cur()}, 32'd0);
  endtask

  task automatic test_add();
    run_op(2'b00, 32'h0, 32'h0, 1'b1);
    run_op(2'b00, 32'h7FFFFFFF, 32'h1, 1'b0);
    run_op(2'b00, 32'hFFFFFFFF, 32'h1, 1'b0);
    run_op(2'b00, 32'h80000000, 32'h80000000, 1'b0);
    run_op(2'b00, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1);
  endtask

  task automatic test_adc();
    run_op(2'b01, 32'h5, 32'hFFFFFFFF, 1'b1);   // R4 tie: result == a with cin
    run_op(2'b01, 32'h5, 32'hFFFFFFFF, 1'b0);
    run_op(2'b01, 32'h0, 32'h0, 1'b1);
    run_op(2'b01, 32'h7FFFFFFF, 32'h0, 1'b1);
    run_op(2'b01, 32'hFFFFFFFF, 32'h0, 1'b1);
  endtask

  task automatic test_sub();
    run_op(2'b10, 32'h5, 32'h5, 1'b0);
    run_op(2'b10, 32'h0, 32'h1, 1'b1);
    run_op(2'b10, 32'h80000000, 32'h1, 1'b0);
    run_op(2'b10, 32'h7FFFFFFF, 32'hFFFFFFFF, 1'b0);
  endtask

  task automatic test_sbc();
    run_op(2'b11, 32'h1234, 32'h1234, 1'b1);    // R6 tie with cin -> C=1, zero
    run_op(2'b11, 32'h1234, 32'h1234, 1'b0);    // R6 tie without cin -> C=0
    run_op(2'b11, 32'h1235, 32'h1234, 1'b0);
    run_op(2'b11, 32'h80000000, 32'h0, 1'b0);
    run_op(2'b11, 32'h0, 32'hFFFFFFFF, 1'b1);
  endtask

  task automatic test_random();
    for (int i = 0; i < 200; i++) begin
      logic [31:0] a, b;
      a = $urandom(); b = $urandom();
      if (i % 7 == 0) b = a;
      run_op(2'(i % 4), a, b, 1'($urandom()));
    end
  endtask

  task automatic test_load();
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      flag_load = 1'b1; flag_din = 4'(k); set_flags = 1'b0;
      @(negedge clk);
      flag_load = 1'b0;
      chk("R9 packed load {N,Z,C,V}", {28'd0, cur()}, {28'd0, 4'(k)});
    end
    exp_flags = 4'hF;
  endtask

  task automatic test_hold();
    run_op(2'b00, 32'h80000000, 32'h80000000, 1'b0);  // flags N0 Z1 C1 V1
    @(negedge clk);
    op_sel = 2'b00; opnd_a = 32'h1; opnd_b = 32'h2; set_flags = 1'b0; flag_load = 1'b0;
    #1 chk("R10 result still live", result, 32'h3);
    @(negedge clk);
    @(negedge clk);
    chk("R10 flags held", {28'd0, cur()}, {28'd0, exp_flags});
  endtask

  task automatic test_priority();
    @(negedge clk);
    op_sel = 2'b00; opnd_a = 32'h0; opnd_b = 32'h0;
    set_flags = 1'b1; flag_load = 1'b1; flag_din = 4'b1001;
    @(negedge clk);
    set_flags = 1'b0; flag_load = 1'b0;
    chk("R11 load beats update", {28'd0, cur()}, 32'h9);
  endtask

  task automatic test_timing();
    @(negedge clk);
    op_sel = 2'b10; opnd_a = 32'h3; opnd_b = 32'h3; set_flags = 1'b1; flag_load = 1'b0;
    @(posedge clk);
    #1 chk("R13 update on sampling edge", {28'd0, cur()}, 32'h6);
    @(negedge clk);
    opnd_b = 32'h4; set_flags = 1'b0;
    @(negedge clk);
    chk("R13 no update after enable drops", {28'd0, cur()}, 32'h6);
  endtask

  initial begin
    rst_n = 1'b0; op_sel = 2'b00; opnd_a = '0; opnd_b = '0; carry_in = 1'b0;
    set_flags = 1'b0; flag_load = 1'b0; flag_din = 4'hF;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_add();
    test_adc();
    test_sub();
    test_sbc();
    test_random();
    test_load();
    test_hold();
    test_priority();
    test_timing();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule